// File: doc/BRIEF.md
# Function-Coded Arithmetic and Logic Unit with Flags

This block is a purely combinational 32-bit arithmetic and logic unit. It has three datapaths: one shared adder/subtractor, a bidirectional barrel shifter and a Boolean unit. A 5-bit function code picks the operation. The code splits into four fields: a subtract bit, a two-bit Boolean/shift selector, a shift-path bit and an arithmetic-path bit. The result is the output of the path that the code selects.

The negative, overflow and carry flags always come from the adder. That adder adds or subtracts depending on the subtract bit. The zero flag looks at the selected result. When the code asks for subtraction, the signed and unsigned less-than outputs are formed from the adder flags, so no separate comparator is needed. The block is used as the execute stage of a simple processor datapath. Operand selection, the register file and memory sit outside it.

Top module: `fcode_alu`

## Requirements
- R1: Function code bits are fn[4]=subtract, fn[3:2]=Boolean/shift selector, fn[1]=shift path, fn[0]=arithmetic path. With fn[0]=1 the result is a_in+b_in when fn[4]=0 and a_in−b_in (mod 2^32) when fn[4]=1, whatever fn[1] and fn[3:2] hold.
- R2: With fn[0]=0 and fn[1]=1, the result is b_in shifted by a shift amount. Selector 10 gives a logical right shift and 11 gives an arithmetic right shift that copies b_in[31]. Selector 00 or 01 gives a left shift that fills with zeros.
- R3: The shift amount is a_in[4:0] only. Bits a_in[31:5] do not change a shift result.
- R4: With fn[0]=0 and fn[1]=0, the selector picks the Boolean result: 00 AND, 01 OR, 10 XOR, 11 NOR of a_in and b_in.
- R5: flag_c is the carry-out of a_in + (b_in XOR {32{fn[4]}}) + fn[4], for every function code.
- R6: flag_v is high exactly when that adder operation overflows as a signed two's-complement operation.
- R7: flag_n equals bit 31 of that adder sum, for every function code.
- R8: flag_z is high exactly when the selected result is all zeros.
- R9: When fn[4]=1, lt_s equals flag_n XOR flag_v, which is the signed comparison a_in < b_in.
- R10: When fn[4]=1, lt_u equals NOT flag_c, which is the unsigned comparison a_in < b_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | Operand A; its low five bits are the shift amount |
| b_in | input | 32 | Operand B; the value that is shifted |
| fn | input | 5 | Function code {subtract, selector[1:0], shift path, arithmetic path} |
| result | output | 32 | Result of the selected path |
| flag_n | output | 1 | Adder sum sign bit |
| flag_v | output | 1 | Adder signed overflow |
| flag_c | output | 1 | Adder carry-out |
| flag_z | output | 1 | Selected result is zero |
| lt_s | output | 1 | Signed less-than, meaningful when subtracting |
| lt_u | output | 1 | Unsigned less-than, meaningful when subtracting |

## Verification
The checker tests every input change against several rules. It checks that the zero flag agrees with the result. It checks that the arithmetic path matches native addition and subtraction. It checks that both less-than outputs match direct comparisons whenever the subtract bit is set. It checks that NOR and left shifts match operators that ignore the upper bits of the shift amount. Some behaviours only the bench's sweeps can show: the exact carry and overflow values over sign-boundary operand pairs, arithmetic right shifts of negative values, and the fact that the unused field bits of each path leave the result unchanged. For these the bench steps a corner-value operand set through all 32 function codes.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned FN_W = 5;

  typedef struct packed {
    logic       sub;
    logic [1:0] sel;
    logic       shft;
    logic       math;
  } alu_fn_t;

  typedef enum logic [1:0] {
    PATH_LOGIC = 2'd0,
    PATH_SHIFT = 2'd1,
    PATH_ARITH = 2'd2
  } alu_path_e;

  function automatic alu_path_e pick_path(input alu_fn_t f);
    if (f.math)      return PATH_ARITH;
    else if (f.shft) return PATH_SHIFT;
    else             return PATH_LOGIC;
  endfunction

  function automatic logic ovf_of(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = b ^ {W{sub}};
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = wide[W-1:0];
  assign carry = wide[W];
  assign ovf   = alu_pkg::ovf_of(a[W-1], b_eff[W-1], wide[W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  input  logic          right,
  input  logic          arith,
  output logic [W-1:0]  out
);
  logic [W-1:0] val_rev;
  logic [W-1:0] fin_rev;
  logic [W-1:0] stage [0:SW];
  logic         fill;

  assign fill = right & arith & val[W-1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign val_rev[i] = val[W-1-i];
    assign fin_rev[i] = stage[SW][W-1-i];
  end

  assign stage[0] = right ? val : val_rev;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
  end

  assign out = right ? stage[SW] : fin_rev;
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] out
);
  always_comb begin
    unique case (sel)
      2'b00:   out = a & b;
      2'b01:   out = a | b;
      2'b10:   out = a ^ b;
      default: out = ~(a | b);
    endcase
  end
endmodule

// File: rtl/fcode_alu.sv
module fcode_alu #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]         a_in,
  input  logic [WIDTH-1:0]         b_in,
  input  logic [alu_pkg::FN_W-1:0] fn,
  output logic [WIDTH-1:0]         result,
  output logic                     flag_n,
  output logic                     flag_v,
  output logic                     flag_c,
  output logic                     flag_z,
  output logic                     lt_s,
  output logic                     lt_u
);
  import alu_pkg::*;
  localparam int unsigned SHW = $clog2(WIDTH);

  alu_fn_t      code;
  alu_path_e    path;
  logic [WIDTH-1:0] sum_w, shift_w, logic_w;
  logic         carry_w, ovf_w;

  assign code = alu_fn_t'(fn);
  assign path = pick_path(code);

  alu_addsub #(.W(WIDTH)) u_add (
    .a(a_in), .b(b_in), .sub(code.sub),
    .sum(sum_w), .carry(carry_w), .ovf(ovf_w)
  );

  alu_shifter #(.W(WIDTH), .SW(SHW)) u_shift (
    .val(b_in), .amt(a_in[SHW-1:0]), .right(code.sel[1]), .arith(code.sel[0]),
    .out(shift_w)
  );

  alu_logic #(.W(WIDTH)) u_bool (
    .a(a_in), .b(b_in), .sel(code.sel), .out(logic_w)
  );

  always_comb begin
    unique case (path)
      PATH_ARITH: result = sum_w;
      PATH_SHIFT: result = shift_w;
      default:    result = logic_w;
    endcase
  end

  assign flag_n = sum_w[WIDTH-1];
  assign flag_v = ovf_w;
  assign flag_c = carry_w;
  assign flag_z = ~|result;
  assign lt_s   = flag_n ^ flag_v;
  assign lt_u   = ~flag_c;
endmodule

// File: rtl/fcode_alu_chk.sv
module fcode_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [4:0]       fn,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_v,
  input logic             flag_c,
  input logic             flag_z,
  input logic             lt_s,
  input logic             lt_u
);
  localparam int unsigned SHW = $clog2(WIDTH);
  logic nvc_seen;
  assign nvc_seen = flag_n | flag_v | flag_c;

  always_comb begin
    // R8
    zero_flag_chk: assert (!flag_z || (result == '0)) else $error("zero flag set on nonzero result");
    // R1
    if (fn[0] && !fn[4])
      add_path_chk: assert (result == a_in + b_in) else $error("add path mismatch");
    // R1
    if (fn[0] && fn[4])
      sub_path_chk: assert (result == a_in - b_in) else $error("subtract path mismatch");
    // R9
    if (fn[4])
      lt_signed_chk: assert (lt_s == ($signed(a_in) < $signed(b_in))) else $error("signed less-than mismatch");
    // R10
    if (fn[4])
      lt_unsigned_chk: assert (lt_u == (a_in < b_in)) else $error("unsigned less-than mismatch");
    // R4
    if (fn[1:0] == 2'b00 && fn[3:2] == 2'b11)
      nor_path_chk: assert (result == ~(a_in | b_in)) else $error("NOR mismatch");
    // R3
    if (fn[1:0] == 2'b10 && fn[3] == 1'b0)
      left_shift_chk: assert (result == (b_in << a_in[SHW-1:0])) else $error("left shift mismatch");
    // R7
    if (nvc_seen && fn[0])
      sign_flag_chk: assert (flag_n == result[WIDTH-1]) else $error("sign flag mismatch");
  end
endmodule

bind fcode_alu fcode_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in(a_in), .b_in(b_in), .fn(fn), .result(result),
  .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z),
  .lt_s(lt_s), .lt_u(lt_u)
);

// File: tb/fcode_alu_test.sv
`timescale 1ns/1ps
module fcode_alu_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] a_in, b_in;
  logic [4:0]  fn;
  logic [31:0] result;
  logic flag_n, flag_v, flag_c, flag_z, lt_s, lt_u;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fcode_alu uut (
    .a_in(a_in), .b_in(b_in), .fn(fn), .result(result),
    .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z),
    .lt_s(lt_s), .lt_u(lt_u)
  );

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'h0000_0002;  3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;  5: return 32'hFFFF_FFFF;
      6: return 32'h5555_5555;  7: return 32'hAAAA_AAAA;
      8: return 32'h0000_001F;  9: return 32'h0000_0020;
      10: return 32'h1234_5678; 11: return 32'hFFFF_FFFE;
      12: return 32'h8000_0001; 13: return 32'hFFFF_FFE3;
      14: return 32'h0000_0010; default: return 32'hC0DE_0F07;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h fn=%b actual=%h expected=%h", req, a_in, b_in, fn, act, exp);
    end
  endtask

  task automatic run_vec(input logic [31:0] a, input logic [31:0] b, input logic [4:0] f);
    logic [32:0] wide;
    longint sa, sb, ssum;
    logic [31:0] exp_res;
    logic [4:0] amt;
    logic e_v;
    @(posedge clk);
    a_in = a; b_in = b; fn = f;
    @(negedge clk);
    amt = a[4:0];
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ssum = f[4] ? sa - sb : sa + sb;
    e_v = (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648);
    wide = f[4] ? ({1'b0, a} + {1'b0, ~b} + 33'd1) : ({1'b0, a} + {1'b0, b});
    if (f[0]) begin
      exp_res = f[4] ? a - b : a + b;
      check(f[4] ? "R1 sub" : "R1 add", result, exp_res);
    end else if (f[1]) begin
      case (f[3:2])
        2'b10: exp_res = b >> amt;
        2'b11: exp_res = 32'($signed(b) >>> amt);
        default: exp_res = b << amt;
      endcase
      check(a[31:5] != 0 ? "R3 shift amount" : "R2 shift", result, exp_res);
    end else begin
      case (f[3:2])
        2'b00: exp_res = a & b;
        2'b01: exp_res = a | b;
        2'b10: exp_res = a ^ b;
        default: exp_res = ~(a | b);
      endcase
      check("R4 boolean", result, exp_res);
    end
    check("R5 carry", {31'd0, flag_c}, {31'd0, wide[32]});
    check("R6 overflow", {31'd0, flag_v}, {31'd0, e_v});
    check("R7 negative", {31'd0, flag_n}, {31'd0, wide[31]});
    check("R8 zero", {31'd0, flag_z}, {31'd0, exp_res == 32'd0});
    if (f[4]) begin
      check("R9 signed lt", {31'd0, lt_s}, {31'd0, sa < sb});
      check("R10 unsigned lt", {31'd0, lt_u}, {31'd0, a < b});
    end
  endtask

  initial begin
    a_in = '0; b_in = '0; fn = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: AND of zeros gives zero result, zero flag high (R8)
    check("R8 reset zero", result, 32'd0);
    check("R8 reset flag", {31'd0, flag_z}, 32'd1);
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int f = 0; f < 32; f++)
          run_vec(pick(i), pick(j), 5'(f));
    // every shift amount, with upper bits of A set to show R3
    for (int s = 0; s < 32; s++)
      for (int f = 0; f < 4; f++) begin
        run_vec(32'hABCD_E000 | 32'(s), 32'h8765_4321, {1'b0, 2'(f), 2'b10});
        run_vec(32'(s), 32'hF00F_0FF1, {1'b1, 2'(f), 2'b10});
      end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule